// File: doc/BRIEF.md
# Token-Chained Serial-Operand Multiplier Wrapper

This block sits between a compiled datapath and a 16x16 multiplier core whose interface is narrower than its function. The core has one shared 16-bit operand input, a load strobe and a 32-bit result output. The wrapper turns a single start token from the global controller into the core's input sequence. It drives operand A with the strobe high, then drives operand B with the strobe low. It then enables the result register at the right clock edge and returns a one-cycle finish token.

Control is a chain of one-hot state flip-flops, and the token moves one state per clock. Two latency modes are supported, selected by `hs_mode`. In fixed mode the token passes through `LAT` wait states before it reaches the output state. In handshake mode the token stays in the operand-B state until the core raises its ready line, and the B state's outputs stay driven for that whole wait. A start token that arrives while a token is already in the chain is refused, and an error flag is raised in that same cycle.

Top module: `opmul_wrap`

## Requirements
- R1: After a synchronous reset no token is present: `core_ld`, `res_en`, `finish_tok` and `start_err` are 0 and `prod_q` is 0.
- R2: In the cycle after an accepted `start_tok`, `core_ld` is 1 and `core_din` equals `opa`. This lasts for exactly one cycle.
- R3: In the cycle after the A cycle, `core_din` equals `opb` and `core_ld` is 0.
- R4: In fixed mode (`hs_mode`=0), `res_en` is 1 for exactly one cycle, `LAT`+2 cycles after the A cycle (cycle 7 after the edge that took the start, for `LAT`=4). It is 0 in the wait cycles.
- R5: `prod_q` loads `core_y` on the rising edge that ends a `res_en` cycle, and it holds its value at every other edge.
- R6: `finish_tok` is 1 for exactly the one cycle that follows a `res_en` cycle.
- R7: In handshake mode, while the token is in the B state and `core_rdy` is 0, the token stays there: `core_din` remains `opb`, `core_ld` stays 0 and `res_en` stays 0.
- R8: In handshake mode, when `core_rdy` is 1 at an edge while the token is in the B state, `res_en` is 1 in the next cycle. `core_y` is captured at the edge that ends that cycle.
- R9: A `start_tok` that arrives while any state holds a token is ignored. `start_err` is 1 in that same cycle, and neither a second load nor a second result enable follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_tok | input | 1 | Start token from the global controller |
| hs_mode | input | 1 | 1 = handshake latency, 0 = fixed latency; held stable during an operation |
| opa | input | 16 | Operand A from the datapath |
| opb | input | 16 | Operand B from the datapath |
| core_din | output | 16 | Shared operand input of the core |
| core_ld | output | 1 | Load strobe of the core |
| core_y | input | 32 | Product output of the core |
| core_rdy | input | 1 | Core result-ready line (handshake mode) |
| res_en | output | 1 | Enable of the datapath result register |
| prod_q | output | 32 | Datapath result register |
| finish_tok | output | 1 | Completion token to the global controller |
| start_err | output | 1 | Start token refused because the chain is busy |

## Verification
On every cycle the assertions check the following. At most one token is in the chain. An accepted start is followed by a single-cycle strobe that carries operand A. Every result enable is followed by a capture of the core output and a single finish pulse. A busy start always raises the error flag. A handshake wait keeps the B state alive with the strobe low. The exact fixed-latency distance, the values of the operands on the shared port, and the fact that a refused start leaves the running sequence unchanged can only be shown by the bench's scenarios. The bench counts cycles against a core output that changes on every clock.

// File: rtl/opmul_wrap.sv
module opmul_wrap #(
  parameter int OPW = 16,
  parameter int RESW = 32,
  parameter int LAT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_tok,
  input  logic            hs_mode,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  output logic [OPW-1:0]  core_din,
  output logic            core_ld,
  input  logic [RESW-1:0] core_y,
  input  logic            core_rdy,
  output logic            res_en,
  output logic [RESW-1:0] prod_q,
  output logic            finish_tok,
  output logic            start_err
);
  localparam int NST = LAT + 3;
  localparam int SOUT = NST - 1;

  logic [NST-1:0] st, nx;
  logic busy;

  assign busy = |st;
  assign start_err = start_tok & busy;

  assign nx[0] = start_tok & ~busy;
  assign nx[1] = st[0] | (hs_mode & st[1] & ~core_rdy);
  assign nx[2] = ~hs_mode & st[1];
  genvar k;
  generate
    for (k = 3; k < SOUT; k++) begin : g_wait
      assign nx[k] = st[k-1];
    end
  endgenerate
  assign nx[SOUT] = hs_mode ? (st[1] & core_rdy) : st[SOUT-1];

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= nx;
  end

  assign core_din = st[0] ? opa : opb;
  assign core_ld  = st[0];
  assign res_en   = st[SOUT];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q     <= '0;
      finish_tok <= 1'b0;
    end else begin
      if (res_en) prod_q <= core_y;
      finish_tok <= res_en;
    end
  end
endmodule

module opmul_wrap_chk #(
  parameter int OPW = 16,
  parameter int RESW = 32,
  parameter int NST = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            start_tok,
  input logic            hs_mode,
  input logic [OPW-1:0]  opa,
  input logic [OPW-1:0]  core_din,
  input logic            core_ld,
  input logic [RESW-1:0] core_y,
  input logic            core_rdy,
  input logic            res_en,
  input logic [RESW-1:0] prod_q,
  input logic            finish_tok,
  input logic            start_err,
  input logic [NST-1:0]  st
);
  a_r9_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st));
  a_r2_start_loads_a: assert property (@(posedge clk) disable iff (rst)
    (start_tok && st == '0) |=> core_ld);
  a_r2_a_on_port: assert property (@(posedge clk) disable iff (rst)
    core_ld |-> core_din == opa);
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    core_ld |=> !core_ld);
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    res_en |=> prod_q == $past(core_y));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !res_en |=> $stable(prod_q));
  a_r6_finish_follows: assert property (@(posedge clk) disable iff (rst)
    res_en |=> finish_tok);
  a_r6_finish_pulse: assert property (@(posedge clk) disable iff (rst)
    finish_tok |=> !finish_tok);
  a_r9_busy_flag: assert property (@(posedge clk) disable iff (rst)
    (start_tok && st != '0) |-> start_err);
  a_r7_hs_hold: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && st[1] && !core_rdy) |=> (st[1] && !core_ld && !res_en));
  a_r8_hs_advance: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && st[1] && core_rdy) |=> res_en);
endmodule

bind opmul_wrap opmul_wrap_chk #(.OPW(OPW), .RESW(RESW), .NST(NST)) u_chk (
  .clk(clk), .rst(rst), .start_tok(start_tok), .hs_mode(hs_mode),
  .opa(opa), .core_din(core_din), .core_ld(core_ld), .core_y(core_y),
  .core_rdy(core_rdy), .res_en(res_en), .prod_q(prod_q),
  .finish_tok(finish_tok), .start_err(start_err), .st(st)
);

// File: tb/opmul_wrap_test.sv
module opmul_wrap_test;
  logic clk = 0, rst = 1, start_tok = 0, hs_mode = 0, core_rdy = 0;
  logic [15:0] opa = 0, opb = 0, core_din;
  logic [31:0] core_y = 0, prod_q, yexp;
  logic core_ld, res_en, finish_tok, start_err;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 core_y = {16'hC0DE, cyc[15:0]};
  end

  opmul_wrap uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 ld", core_ld, 0);
    chk("R1 res_en", res_en, 0);
    chk("R1 finish", finish_tok, 0);
    chk("R1 err", start_err, 0);
    chk("R1 prod", prod_q, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_fixed(input logic [15:0] a, input logic [15:0] b);
    hs_mode = 0; opa = a; opb = b; start_tok = 1;
    @(negedge clk); start_tok = 0;
    chk("R2 ld", core_ld, 1);
    chk("R2 din", core_din, a);
    @(negedge clk);
    chk("R3 ld", core_ld, 0);
    chk("R3 din", core_din, b);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 wait res_en", res_en, 0);
      chk("R2 no reload", core_ld, 0);
    end
    @(negedge clk);
    chk("R4 res_en", res_en, 1);
    yexp = core_y;
    @(negedge clk);
    chk("R6 finish", finish_tok, 1);
    chk("R5 prod", prod_q, yexp);
    chk("R4 single", res_en, 0);
    @(negedge clk);
    chk("R6 pulse", finish_tok, 0);
    chk("R5 hold", prod_q, yexp);
  endtask

  task automatic t_busy();
    hs_mode = 0; opa = 16'h1111; opb = 16'h2222; start_tok = 1;
    @(negedge clk); start_tok = 0;
    @(negedge clk);
    start_tok = 1; #0.5;
    chk("R9 err", start_err, 1);
    @(negedge clk); start_tok = 0;
    chk("R9 no reload", core_ld, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no early res", res_en, 0);
      chk("R9 no reload", core_ld, 0);
    end
    @(negedge clk);
    chk("R9 res_en once", res_en, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 no second res", res_en, 0);
      chk("R9 no second ld", core_ld, 0);
    end
  endtask

  task automatic t_hs(input int waits);
    hs_mode = 1; opa = 16'hABCD; opb = 16'h0F0F; core_rdy = 0; start_tok = 1;
    @(negedge clk); start_tok = 0;
    chk("R2 hs ld", core_ld, 1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R7 din", core_din, 16'h0F0F);
      chk("R7 ld", core_ld, 0);
      chk("R7 res_en", res_en, 0);
    end
    core_rdy = 1;
    @(negedge clk); core_rdy = 0;
    chk("R8 res_en", res_en, 1);
    yexp = core_y;
    @(negedge clk);
    chk("R8 prod", prod_q, yexp);
    chk("R6 hs finish", finish_tok, 1);
    chk("R8 single", res_en, 0);
    @(negedge clk);
    hs_mode = 0;
  endtask

  initial begin
    t_reset();
    t_fixed(16'h1234, 16'h00FF);
    t_fixed(16'hFFFF, 16'h8001);
    t_busy();
    t_hs(4);
    t_hs(1);
    t_fixed(16'h0001, 16'h0002);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule